// File: doc/BRIEF.md
# Sample Interrupt Strobe Generator

This block produces a free-running, active-low interrupt strobe that paces the exchange of samples between a baseband front end and a DSP. It runs from the master clock and needs no acknowledge from the receiver. The strobe repeats for as long as it is enabled. Both its repetition interval and its low time depend on a mode select. The digital mode repeats every 800 master cycles (48.6 kHz at 38.88 MHz) and holds the strobe low for 6.5 cycles. The analog mode repeats every 972 cycles (40 kHz) and holds it low for 5.5 cycles.

A period counter chooses the mode at the start of every period. A change of mode therefore never shortens or cuts a pulse. The half-cycle ending of each pulse comes from a falling-edge register that extends the rising-edge pulse by half a master cycle. A disable input forces the strobe high. When the block is enabled again, the counter starts from zero and the first pulse begins at once. The asynchronous reset is released through a two-stage synchronizer.

Top module: `sample_irq_gen`

## Requirements
- R1: While reset is low, `irq_n` is high. After `rst_n` rises, the first two rising clock edges still hold the block in reset. With `dis` low, the strobe goes low at the third rising edge.
- R2: With `mode_dig`=1 and the strobe steadily enabled, consecutive falling edges of `irq_n` are `PER_DIG` master cycles apart.
- R3: With `mode_dig`=0 and the strobe steadily enabled, consecutive falling edges of `irq_n` are `PER_ANA` master cycles apart.
- R4: In digital mode each low pulse lasts `LOW_HALF_DIG` half-cycles (13, or 6.5 cycles, by default). It starts on a rising edge and, when the count is odd, ends on a falling edge.
- R5: In analog mode each low pulse lasts `LOW_HALF_ANA` half-cycles (11, or 5.5 cycles, by default).
- R6: A rising edge that samples `dis`=1 stops the strobe. From the next falling edge on, `irq_n` stays high for as long as `dis` stays 1, even when the disable arrives in the middle of a pulse.
- R7: The first rising edge that samples `dis`=0 after a disable restarts the period at count zero. `irq_n` goes low at that edge, in the mode sampled at that edge.
- R8: `mode_dig` is sampled only at the edge that starts a period. A change of mode in the middle of a period lets the current period finish with its old length and pulse width.
- R9: The strobe repeats with no input activity; there is no acknowledge input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock; both edges are used |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| mode_dig | input | 1 | 1 selects digital mode, 0 selects analog mode |
| dis | input | 1 | 1 stops the strobe and holds it high |
| irq_n | output | 1 | Active-low interrupt strobe |

## Verification
The bench builds the block with shortened periods of 40 cycles (digital) and 52 cycles (analog) and keeps the default pulse widths of 13 and 11 half-cycles. With these periods, many period boundaries, mode switches and mid-pulse disables fit in a short run. A reference model compares the strobe against the expected value in both halves of every clock cycle. A half-cycle counter measures each period and each low width.

// File: rtl/sample_irq_pkg.sv
package sample_irq_pkg;
  typedef enum logic {
    MODE_ANALOG  = 1'b0,
    MODE_DIGITAL = 1'b1
  } irq_mode_e;
endpackage

// File: rtl/sirq_rst_sync.sv
module sirq_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic stage_q;
  logic out_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      stage_q <= 1'b0;
      out_q   <= 1'b0;
    end else begin
      stage_q <= 1'b1;
      out_q   <= stage_q;
    end
  end

  assign srst_n = out_q;
endmodule

// File: rtl/sirq_period_ctr.sv
module sirq_period_ctr
  import sample_irq_pkg::*;
#(
  parameter int PER_DIG      = 800,
  parameter int PER_ANA      = 972,
  parameter int LOW_HALF_DIG = 13,
  parameter int LOW_HALF_ANA = 11,
  parameter int CW           = 10
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            mode_dig,
  input  logic            dis,
  output logic [CW-1:0]   cnt_o,
  output logic            run_o,
  output irq_mode_e       mode_o,
  output logic            pulse_o
);
  localparam logic [CW-1:0] LAST_DIG = CW'(PER_DIG - 1);
  localparam logic [CW-1:0] LAST_ANA = CW'(PER_ANA - 1);
  localparam logic [CW-1:0] FULL_DIG = CW'(LOW_HALF_DIG / 2);
  localparam logic [CW-1:0] FULL_ANA = CW'(LOW_HALF_ANA / 2);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          run_q, run_d;
  irq_mode_e     mode_q, mode_d;
  logic          pulse_q, pulse_d;
  logic [CW-1:0] last_cur;
  logic [CW-1:0] full_nxt;
  logic          at_last;
  logic          adv;

  assign last_cur = (mode_q == MODE_DIGITAL) ? LAST_DIG : LAST_ANA;
  assign at_last  = (cnt_q == last_cur);
  // clock enable: nothing moves while idle and disabled
  assign adv      = run_q | ~dis;

  always_comb begin
    cnt_d  = cnt_q;
    run_d  = run_q;
    mode_d = mode_q;
    if (dis) begin
      run_d = 1'b0;
      cnt_d = '0;
    end else if (!run_q || at_last) begin
      run_d  = 1'b1;
      cnt_d  = '0;
      mode_d = mode_dig ? MODE_DIGITAL : MODE_ANALOG;
    end else begin
      cnt_d = cnt_q + 1'b1;
    end
    full_nxt = (mode_d == MODE_DIGITAL) ? FULL_DIG : FULL_ANA;
    pulse_d  = run_d & (cnt_d < full_nxt);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      run_q   <= 1'b0;
      mode_q  <= MODE_ANALOG;
      pulse_q <= 1'b0;
    end else if (adv) begin
      cnt_q   <= cnt_d;
      run_q   <= run_d;
      mode_q  <= mode_d;
      pulse_q <= pulse_d;
    end
  end

  assign cnt_o   = cnt_q;
  assign run_o   = run_q;
  assign mode_o  = mode_q;
  assign pulse_o = pulse_q;
endmodule

// File: rtl/sirq_half_ext.sv
module sirq_half_ext
  import sample_irq_pkg::*;
#(
  parameter int LOW_HALF_DIG = 13,
  parameter int LOW_HALF_ANA = 11
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      pulse,
  input  irq_mode_e mode,
  output logic      irq_n
);
  localparam bit ODD_DIG = (LOW_HALF_DIG % 2) == 1;
  localparam bit ODD_ANA = (LOW_HALF_ANA % 2) == 1;

  logic half_q;

  generate
    if (ODD_DIG || ODD_ANA) begin : g_half
      logic odd_sel;
      assign odd_sel = (mode == MODE_DIGITAL) ? ODD_DIG : ODD_ANA;
      // falling-edge copy of the pulse extends it by half a cycle
      always_ff @(negedge clk or negedge rst_n) begin
        if (!rst_n) half_q <= 1'b0;
        else        half_q <= pulse & odd_sel;
      end
    end else begin : g_no_half
      assign half_q = 1'b0;
    end
  endgenerate

  assign irq_n = ~(pulse | half_q);
endmodule

// File: rtl/sample_irq_gen.sv
module sample_irq_gen
  import sample_irq_pkg::*;
#(
  parameter int PER_DIG      = 800,
  parameter int PER_ANA      = 972,
  parameter int LOW_HALF_DIG = 13,
  parameter int LOW_HALF_ANA = 11
) (
  input  logic clk,
  input  logic rst_n,
  input  logic mode_dig,
  input  logic dis,
  output logic irq_n
);
  localparam int PER_MAX = (PER_DIG > PER_ANA) ? PER_DIG : PER_ANA;
  localparam int CW      = $clog2(PER_MAX);

  logic          srst_n;
  logic [CW-1:0] cnt_q;
  logic          run_q;
  irq_mode_e     mode_q;
  logic          pulse_q;

  sirq_rst_sync u_rst (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (srst_n)
  );

  sirq_period_ctr #(
    .PER_DIG      (PER_DIG),
    .PER_ANA      (PER_ANA),
    .LOW_HALF_DIG (LOW_HALF_DIG),
    .LOW_HALF_ANA (LOW_HALF_ANA),
    .CW           (CW)
  ) u_ctr (
    .clk      (clk),
    .rst_n    (srst_n),
    .mode_dig (mode_dig),
    .dis      (dis),
    .cnt_o    (cnt_q),
    .run_o    (run_q),
    .mode_o   (mode_q),
    .pulse_o  (pulse_q)
  );

  sirq_half_ext #(
    .LOW_HALF_DIG (LOW_HALF_DIG),
    .LOW_HALF_ANA (LOW_HALF_ANA)
  ) u_half (
    .clk   (clk),
    .rst_n (srst_n),
    .pulse (pulse_q),
    .mode  (mode_q),
    .irq_n (irq_n)
  );
endmodule

// File: rtl/sample_irq_gen_chk.sv
module sample_irq_gen_chk #(
  parameter int PER_DIG = 800,
  parameter int PER_ANA = 972,
  parameter int CW      = 10
) (
  input logic          clk,
  input logic          rst_n,
  input logic          dis,
  input logic          irq_n,
  input logic [CW-1:0] cnt,
  input logic          run,
  input logic          mode
);
  logic [CW-1:0] last;
  assign last = mode ? CW'(PER_DIG - 1) : CW'(PER_ANA - 1);

  // R1
  rst_hold_chk: assert property (@(posedge clk) !rst_n |-> irq_n);

  // R6
  dis_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(dis) |-> irq_n);

  // R2 R3
  cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= last);

  // R2 R3
  wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && cnt == last && !dis) |=> (cnt == '0));

  // R8
  mode_switch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(mode) |-> (cnt == '0));

  // R7
  start_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && cnt == '0) |-> !irq_n);
endmodule

bind sample_irq_gen sample_irq_gen_chk #(
  .PER_DIG (PER_DIG),
  .PER_ANA (PER_ANA),
  .CW      (CW)
) u_chk (
  .clk   (clk),
  .rst_n (rst_n),
  .dis   (dis),
  .irq_n (irq_n),
  .cnt   (cnt_q),
  .run   (run_q),
  .mode  (mode_q)
);

// File: tb/sample_irq_gen_bench.sv
`timescale 1ns/1ps
module sample_irq_gen_bench;
  localparam int PD = 40;
  localparam int PA = 52;
  localparam int LD = 13;
  localparam int LA = 11;

  logic clk = 1'b0;
  logic rst_n;
  logic mode_dig;
  logic dis;
  logic irq_n;

  int n_cmp = 0;
  int n_bad = 0;
  string cur_req = "R1";

  always #2 clk = ~clk;

  sample_irq_gen #(
    .PER_DIG (PD), .PER_ANA (PA), .LOW_HALF_DIG (LD), .LOW_HALF_ANA (LA)
  ) u_sample_irq_gen (
    .clk (clk), .rst_n (rst_n), .mode_dig (mode_dig), .dis (dis), .irq_n (irq_n)
  );

  function automatic int per_of(bit m);
    return m ? PD : PA;
  endfunction
  function automatic int low_of(bit m);
    return m ? LD : LA;
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s t=%0t actual=%0d expected=%0d", req, $time, act, exp);
    end
  endtask

  // half-cycle measurement
  int  hc = 0;
  int  last_fall = -1;
  int  meas_width = 0;
  int  falls = 0;
  int  per_q[$];
  logic prev_irq = 1'b1;

  task automatic observe(bit exp_high);
    chk(irq_n === exp_high, cur_req, int'(irq_n), int'(exp_high));
    hc++;
    if (prev_irq && !irq_n) begin
      if (last_fall >= 0) per_q.push_back(hc - last_fall);
      last_fall = hc;
      falls++;
    end else if (!prev_irq && irq_n) begin
      meas_width = hc - last_fall;
    end
    prev_irq = irq_n;
  endtask

  // reference model, compared in both halves of every cycle
  int m_rs = 0;
  bit m_run = 0;
  int m_pos = 0;
  bit m_mode = 0;
  bit m_tail = 0;
  bit m_second = 0;

  initial begin
    bit first_low;
    forever begin
      @(posedge clk);
      if (!rst_n) begin
        m_rs = 0; m_run = 0; m_pos = 0; m_mode = 0; m_tail = 0;
      end else if (m_rs < 2) begin
        m_rs++; m_tail = 0;
      end else begin
        m_tail = m_second && (low_of(m_mode) % 2 == 1);
        if (dis) begin
          m_run = 0; m_pos = 0;
        end else if (!m_run || m_pos == per_of(m_mode) - 1) begin
          m_run = 1; m_pos = 0; m_mode = mode_dig;
        end else begin
          m_pos++;
        end
      end
      first_low = (m_run && (2 * m_pos < low_of(m_mode))) || m_tail;
      #1 observe(!first_low);
      @(negedge clk);
      m_second = m_run && (2 * m_pos + 1 < low_of(m_mode));
      #1 observe(!m_second);
    end
  end

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    #(200000 * 4);
    chk(1'b0, "watchdog", 0, 1);
    finish_run();
  end

  initial begin
    int nf;
    rst_n = 1'b0; dis = 1'b0; mode_dig = 1'b1;
    step(5);
    chk(irq_n === 1'b1, "R1 reset high", int'(irq_n), 1);
    rst_n = 1'b1;
    step(2);
    chk(irq_n === 1'b1, "R1 sync hold", int'(irq_n), 1);
    step(1);
    chk(irq_n === 1'b0, "R1 first pulse", int'(irq_n), 0);

    // R2 R4 R9 steady digital
    cur_req = "R2";
    step(5 * PD);
    chk(per_q.size() >= 4, "R9 free-running", per_q.size(), 4);
    chk(per_q[$] == 2 * PD, "R2 period", per_q[$], 2 * PD);
    chk(meas_width == LD, "R4 width", meas_width, LD);

    // R8 switch mid-period
    @(negedge irq_n); step(10);
    per_q.delete();
    cur_req = "R8";
    mode_dig = 1'b0;
    step(2 * PD + 3 * PA);
    chk(per_q[0] == 2 * PD, "R8 old period kept", per_q[0], 2 * PD);
    chk(per_q[1] == 2 * PA, "R8 new period", per_q[1], 2 * PA);
    cur_req = "R3";
    step(2 * PA);
    chk(per_q[$] == 2 * PA, "R3 period", per_q[$], 2 * PA);
    chk(meas_width == LA, "R5 width", meas_width, LA);

    // R8 switch during a pulse
    @(negedge irq_n); step(2);
    cur_req = "R8";
    mode_dig = 1'b1;
    step(3 * PA);
    chk(meas_width == LD, "R8 digital width after switch", meas_width, LD);

    // R6 disable mid-pulse
    @(negedge irq_n); step(3);
    cur_req = "R6";
    dis = 1'b1;
    nf = falls;
    step(3 * PA);
    chk(irq_n === 1'b1, "R6 held high", int'(irq_n), 1);
    chk(falls == nf, "R6 no pulse", falls, nf);

    // R7 re-enable in analog mode chosen while disabled
    mode_dig = 1'b0;
    step(4);
    cur_req = "R7";
    dis = 1'b0;
    @(posedge clk); #1;
    chk(irq_n === 1'b0, "R7 restart low", int'(irq_n), 0);
    step(3 * PA);
    chk(meas_width == LA, "R7 width after restart", meas_width, LA);

    // R6 one-cycle disable that hits the half-cycle tail
    mode_dig = 1'b1;
    step(PA);
    @(negedge irq_n); step(LD / 2);
    cur_req = "R6";
    dis = 1'b1;
    step(1);
    dis = 1'b0;
    @(posedge clk); #1;
    chk(irq_n === 1'b0, "R7 restart after short disable", int'(irq_n), 0);
    step(3 * PD);
    chk(per_q[$] == 2 * PD, "R2 period after restart", per_q[$], 2 * PD);
    finish_run();
  end
endmodule